// File: doc/BRIEF.md
# Serial Bus Packet Timeout Monitor

This block guards a two-wire serial slave against packets that take too long. It receives decoded START and STOP events from the slave's bit engine, plus a millisecond tick from a prescaler. Timing begins at the START that opens a packet and ends only at a STOP. A repeated START in the middle of a read does not reset the timer. If the running packet is still open when its time allowance runs out, the block raises an abort. The slave uses the abort to float its lines and throw the packet away.

The allowance is a fixed base for ordinary packets. While the slave reports that a block read is in progress, the allowance becomes the base plus a per-byte increment multiplied by the reported block length. The result is raised to a floor value if it falls below it, and capped at the counter's largest value if it would overflow. The timer counts only prescaled ticks, so its behaviour does not depend on the serial bit rate.

The control is a three-state machine:
- IDLE: no packet is open. START moves it to TIMING.
- TIMING: a packet is being timed. STOP moves it to IDLE. Reaching the allowance moves it to ABORTED. A repeated START leaves it in TIMING.
- ABORTED: the abort is held. STOP moves it to IDLE, and START moves it to TIMING with a fresh count. STOP has priority when both arrive in the same cycle.

Top module: `pkt_timeout_mon`

## Requirements
- R1: After reset, `bus_abort` is 0 and no packet is being timed.
- R2: With `blk_rd_active` low, `bus_abort` rises on the first clock edge after the BASE_MS-th (default 20) `ms_tick` counted since the opening START. It does not rise before that.
- R3: A STOP while timing ends the packet. No abort follows, however many ticks arrive afterwards.
- R4: A START while a packet is already being timed does not restart the count. The abort still comes BASE_MS ticks after the first START.
- R5: Once raised, `bus_abort` stays at 1 until a START or a STOP is seen, and clears on the following edge. A START in that state opens a new packet with a full, fresh allowance.
- R6: With `blk_rd_active` high, the allowance is BASE_MS + PER_BYTE_MS × `blk_rd_len` ticks (defaults 20 and 4), when that value lies between the floor and the cap.
- R7: For block reads, the allowance is never below MIN_BLK_MS (default 32) ticks. For example, lengths 0 and 3 both give 32.
- R8: For block reads, the allowance saturates at 2^CNT_W − 1 (default 1023) ticks when the sum exceeds it. For example, length 255 gives 1023.
- R9: Ticks that arrive while no packet is open have no effect. They cause no abort and do not shorten the next packet's allowance.
- R10: Time is measured only in `ms_tick` pulses. Any number of clock cycles without a tick never causes an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond from the prescaler |
| bus_start | input | 1 | One-cycle pulse: START or repeated START detected |
| bus_stop | input | 1 | One-cycle pulse: STOP detected |
| blk_rd_active | input | 1 | High while the current packet is a block read |
| blk_rd_len | input | LEN_W | Byte count of the block read |
| bus_abort | output | 1 | Timeout abort: release the lines and discard the packet |

## Verification
The hardest case to reach is the saturated allowance. It only appears during a block read long enough that the base plus the scaled length overflows the counter, and confirming it takes more than a thousand ticks without any STOP. The bench holds a maximum-length block read open and sends 1022 ticks, checking that no abort has appeared. It then sends one more tick and checks that the abort follows on the next edge. The repeated-START case is reached by inserting a second START partway through the count and checking that the abort edge does not move.

// File: rtl/pto_pkg.sv
package pto_pkg;

    typedef enum logic [1:0] {
        PTO_IDLE    = 2'd0,
        PTO_TIMING  = 2'd1,
        PTO_ABORTED = 2'd2
    } pto_state_e;

endpackage

// File: rtl/pto_limit.sv
module pto_limit #(
    parameter int CNT_W       = 10,
    parameter int LEN_W       = 8,
    parameter int BASE_MS     = 20,
    parameter int PER_BYTE_MS = 4,
    parameter int MIN_BLK_MS  = 32
) (
    input  logic             blk_rd_active,
    input  logic [LEN_W-1:0] blk_rd_len,
    output logic [CNT_W-1:0] limit
);

    localparam int SUM_W = CNT_W + LEN_W + 4;
    localparam logic [SUM_W-1:0] CAP   = SUM_W'((1 << CNT_W) - 1);
    localparam logic [SUM_W-1:0] BASE  = SUM_W'(BASE_MS);
    localparam logic [SUM_W-1:0] STEP  = SUM_W'(PER_BYTE_MS);
    localparam logic [SUM_W-1:0] FLOOR = SUM_W'(MIN_BLK_MS);

    logic [SUM_W-1:0] scaled;
    logic [SUM_W-1:0] floored;
    logic [SUM_W-1:0] capped;

    always_comb begin
        scaled  = BASE + STEP * SUM_W'(blk_rd_len);
        floored = (scaled < FLOOR) ? FLOOR : scaled;
        capped  = (floored > CAP) ? CAP : floored;
        if (blk_rd_active) begin
            limit = capped[CNT_W-1:0];
        end else begin
            limit = (BASE > CAP) ? CAP[CNT_W-1:0] : BASE[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/pto_counter.sv
module pto_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pkt_timeout_mon.sv
module pkt_timeout_mon #(
    parameter int CNT_W       = 10,
    parameter int LEN_W       = 8,
    parameter int BASE_MS     = 20,
    parameter int PER_BYTE_MS = 4,
    parameter int MIN_BLK_MS  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             blk_rd_active,
    input  logic [LEN_W-1:0] blk_rd_len,
    output logic             bus_abort
);

    import pto_pkg::*;

    pto_state_e       state_q;
    pto_state_e       state_d;
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] cur_limit;
    logic             expired;
    logic             cnt_clr;
    logic             cnt_inc;

    pto_limit #(
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .BASE_MS    (BASE_MS),
        .PER_BYTE_MS(PER_BYTE_MS),
        .MIN_BLK_MS (MIN_BLK_MS)
    ) u_limit (
        .blk_rd_active(blk_rd_active),
        .blk_rd_len   (blk_rd_len),
        .limit        (cur_limit)
    );

    assign cnt_clr = (state_q != PTO_TIMING);
    assign cnt_inc = (state_q == PTO_TIMING) && ms_tick;

    pto_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .count(tick_cnt)
    );

    assign expired = (tick_cnt >= cur_limit);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTO_IDLE: begin
                if (bus_start) state_d = PTO_TIMING;
            end
            PTO_TIMING: begin
                if (bus_stop)     state_d = PTO_IDLE;
                else if (expired) state_d = PTO_ABORTED;
            end
            PTO_ABORTED: begin
                if (bus_stop)       state_d = PTO_IDLE;
                else if (bus_start) state_d = PTO_TIMING;
            end
            default: state_d = PTO_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTO_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) bus_abort <= 1'b0;
        else        bus_abort <= (state_d == PTO_ABORTED);
    end

endmodule

// File: rtl/pto_checker.sv
module pto_checker #(
    parameter int CNT_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ms_tick,
    input logic               bus_start,
    input logic               bus_stop,
    input logic               bus_abort,
    input pto_pkg::pto_state_e state,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   limit
);

    import pto_pkg::*;

    AST_ABORT_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_abort) |-> ($past(cnt) >= $past(limit))); // R2

    AST_STOP_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTO_TIMING && bus_stop) |=> (!bus_abort && state == PTO_IDLE)); // R3

    AST_RESTART_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTO_TIMING && bus_start && !bus_stop && cnt < limit) |=> (cnt >= $past(cnt))); // R4

    AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_abort && !bus_start && !bus_stop) |=> bus_abort); // R5

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_abort && (bus_start || bus_stop)) |=> !bus_abort); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTO_IDLE && !bus_start) |=> (!bus_abort && cnt == '0)); // R9

    AST_NO_TICK_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTO_TIMING && !ms_tick && !bus_stop) |=> (cnt == $past(cnt))); // R10

endmodule

bind pkt_timeout_mon pto_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .bus_abort(bus_abort),
    .state    (state_q),
    .cnt      (tick_cnt),
    .limit    (cur_limit)
);

// File: tb/pkt_timeout_mon_test.sv
module pkt_timeout_mon_test;

    localparam int CNT_W = 10;
    localparam int LEN_W = 8;
    localparam int BASE  = 20;
    localparam int STEP  = 4;
    localparam int FLOOR = 32;
    localparam int CAP   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_tick = 1'b0;
    logic             bus_start = 1'b0;
    logic             bus_stop = 1'b0;
    logic             blk_rd_active = 1'b0;
    logic [LEN_W-1:0] blk_rd_len = '0;
    logic             bus_abort;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pkt_timeout_mon uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .blk_rd_active(blk_rd_active),
        .blk_rd_len   (blk_rd_len),
        .bus_abort    (bus_abort)
    );

    function automatic int expect_limit(input bit blk, input int len);
        int v;
        if (!blk) return BASE;
        v = BASE + STEP * len;
        if (v < FLOOR) v = FLOOR;
        if (v > CAP) v = CAP;
        return v;
    endfunction

    task automatic check(input string req, input logic actual, input logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: bus_abort=%0b expected=%0b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        idle(2);
        check("R1 reset", bus_abort, 1'b0);
    endtask

    // R9: idle ticks ignored, next packet gets a full allowance (R2)
    task automatic t_idle_ticks();
        ticks(50);
        idle(1);
        check("R9 idle ticks", bus_abort, 1'b0);
        pulse_start();
        ticks(BASE - 1);
        idle(1);
        check("R9 full window after idle ticks", bus_abort, 1'b0);
        ticks(1);
        idle(1);
        check("R2 abort at base limit", bus_abort, 1'b1);
        pulse_stop();
        idle(1);
        check("R5 stop clears abort", bus_abort, 1'b0);
    endtask

    // R2 with irregular tick spacing
    task automatic t_normal();
        pulse_start();
        for (int i = 0; i < BASE - 1; i++) begin
            ticks(1);
            idle(i % 3);
        end
        idle(5);
        check("R2 no early abort", bus_abort, 1'b0);
        ticks(1);
        idle(1);
        check("R2 abort after base ticks", bus_abort, 1'b1);
        pulse_stop();
    endtask

    // R3
    task automatic t_stop_early();
        pulse_start();
        ticks(10);
        pulse_stop();
        ticks(40);
        idle(1);
        check("R3 stop ends timing", bus_abort, 1'b0);
    endtask

    // R4 and R5
    task automatic t_restart();
        pulse_start();
        ticks(12);
        pulse_start();
        ticks(BASE - 13);
        idle(1);
        check("R4 before limit after repeated start", bus_abort, 1'b0);
        ticks(1);
        idle(1);
        check("R4 repeated start does not restart", bus_abort, 1'b1);
        ticks(5);
        idle(10);
        check("R5 abort held", bus_abort, 1'b1);
        pulse_start();
        check("R5 start clears abort", bus_abort, 1'b0);
        ticks(BASE - 1);
        idle(1);
        check("R5 fresh window after start", bus_abort, 1'b0);
        ticks(1);
        idle(1);
        check("R5 fresh packet times out", bus_abort, 1'b1);
        pulse_stop();
    endtask

    // R6, R7, R8
    task automatic t_block(input string req, input int len);
        int lim;
        lim = expect_limit(1'b1, len);
        blk_rd_active = 1'b1;
        blk_rd_len = LEN_W'(len);
        pulse_start();
        ticks(lim - 1);
        idle(2);
        check({req, " before block limit"}, bus_abort, 1'b0);
        ticks(1);
        idle(1);
        check({req, " at block limit"}, bus_abort, 1'b1);
        pulse_stop();
        blk_rd_active = 1'b0;
        blk_rd_len = '0;
    endtask

    // R10
    task automatic t_no_tick();
        pulse_start();
        ticks(BASE - 1);
        idle(600);
        check("R10 clocks without ticks", bus_abort, 1'b0);
        pulse_stop();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_idle_ticks();
        t_normal();
        t_stop_early();
        t_restart();
        t_block("R6 len5", 5);
        t_block("R6 len200", 200);
        t_block("R7 len0", 0);
        t_block("R7 len3", 3);
        t_block("R8 len255", 255);
        t_no_tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule